// File: doc/BRIEF.md
# Masked-CRC Wake Event Detector

This block watches a byte-wide receive stream and raises an active-low wake request when a frame matches one of four programmable templates, or when the link goes up or down. Each template picks any subset of the first 64 bytes of a frame with a byte mask. A CRC-32 is accumulated over only the picked bytes, and the result is compared with a stored expected value on the last byte of the frame.

Each wake source keeps its own sticky flag. The output is asserted while any enabled source flag is set and the global output enable is on. A flag, and with it the request, stays set until software clears the enable bit of the source that raised it. Software programs enables, masks and expected CRCs through a simple 16-bit write-only port.

Top module: `wake_crc_detector`

## Requirements
- R1: After reset, `wake_n` is 1 and all enables, flags, masks and expected values are 0. A frame that matches a programmed template raises no wake request until its enable bit is written.
- R2: Writes go to address 0 for control and to address 8+8t for template t. Control bit 0 enables link-up, bit 1 enables link-down, bit 2+t enables template t and bit 15 is the global output enable. Template offsets +0..+3 are mask words, where bit b of word w selects frame byte 16w+b. Offset +4 is the low half of the expected CRC and +5 is the high half.
- R3: The CRC is IEEE CRC-32: reflected polynomial 0xEDB88320, all-ones start and a final inversion. It is computed over the mask-selected bytes only, counting byte 0 as the byte marked by `rx_sof`. Unselected bytes do not change the result.
- R4: Bytes at index 64 and above never take part in any template's CRC.
- R5: On the byte with `rx_eof` and `rx_valid` set, a CRC equal to the stored value of an enabled template drives `wake_n` to 0 from the next clock edge.
- R6: A CRC mismatch, or a match on a disabled template, leaves `wake_n` at 1.
- R7: A frame shorter than 64 bytes is evaluated at its end over the selected bytes that actually arrived.
- R8: `link_up` passes through a two-flop synchronizer. A 0-to-1 change with bit 0 set, or a 1-to-0 change with bit 1 set, drives `wake_n` to 0 within 5 cycles. A change of the other polarity has no effect, and the level present at reset is not seen as a change.
- R9: Once asserted, `wake_n` stays 0 until a control write clears the enable bit of every source holding a flag. It returns to 1 in the cycle after that write. Control writes that keep those bits set do not release it.
- R10: While bit 15 is 0, `wake_n` stays 1 but flags are still recorded. Setting bit 15 later asserts `wake_n` for a flag already held.
- R11: The four templates evaluate the same frame in parallel and independently. Clearing one matched template's enable leaves the request held by another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_valid) |
| rx_valid | input | 1 | rx_data carries a frame byte this cycle |
| rx_data | input | 8 | Received frame byte |
| rx_eof | input | 1 | Marks the last byte of a frame (qualified by rx_valid) |
| link_up | input | 1 | Asynchronous link status level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register write address |
| cfg_wdata | input | 16 | Register write data |
| wake_n | output | 1 | Active-low wake request |

## Verification
The bound checker watches four things on every cycle. It checks that the request holds across any cycle without a control write, and that a control write clearing all enables releases it on the next cycle. It checks that every falling edge of `wake_n` follows a frame end, a synchronized link change or a control write. It also checks that the byte position counter never passes the 64-byte window. Whether a CRC over a particular mask and frame is right, whether bytes past the window are ignored, and how link polarity and the global enable behave can only be shown by the bench's directed frames and link toggles against CRCs it computes on its own.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
    localparam int          CTRL_ADDR   = 0;
    localparam int          OE_BIT      = 15;
    localparam int          SRC_LUP     = 0;
    localparam int          SRC_LDN     = 1;
    localparam int          SRC_TPL0    = 2;
    localparam int          TPL_BASE    = 8;
    localparam int          TPL_STRIDE  = 8;
    localparam int          OFF_CRC_LO  = 4;
    localparam int          OFF_CRC_HI  = 5;

    // Fold one byte, LSB first, into a reflected CRC-32 register.
    function automatic logic [31:0] crc_step(input logic [31:0] cur, input logic [7:0] b);
        logic [31:0] c;
        c = cur;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY;
            else             c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/wake_crc_lane.sv
module wake_crc_lane
    import wake_pkg::*;
#(
    parameter int WINDOW = 64,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic [CNT_W-1:0]  byte_idx,
    input  logic [WINDOW-1:0] mask,
    input  logic [31:0]       exp_crc,
    output logic              hit
);
    localparam int IDX_W = $clog2(WINDOW);

    logic [31:0] crc_d, crc_q;
    logic [31:0] base;
    logic        take;

    always_comb begin
        base  = rx_sof ? CRC_INIT : crc_q;
        take  = (byte_idx < CNT_W'(WINDOW)) && mask[byte_idx[IDX_W-1:0]];
        crc_d = crc_q;
        if (rx_valid) crc_d = take ? crc_step(base, rx_data) : base;
        hit   = rx_valid && rx_eof && ((~crc_d) == exp_crc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= CRC_INIT;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/wake_link_edge.sv
module wake_link_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic went_up,
    output logic went_down
);
    typedef struct packed {
        logic       s1;
        logic       s2;
        logic       last;
        logic [1:0] fill;
    } link_t;

    link_t l_d, l_q;
    logic  ready;

    always_comb begin
        l_d      = l_q;
        l_d.s1   = link_up;
        l_d.s2   = l_q.s1;
        l_d.last = l_q.s2;
        if (l_q.fill != 2'd3) l_d.fill = l_q.fill + 2'd1;
        ready     = (l_q.fill == 2'd3);
        went_up   = ready &&  l_q.s2 && !l_q.last;
        went_down = ready && !l_q.s2 &&  l_q.last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end
endmodule

// File: rtl/wake_crc_detector.sv
module wake_crc_detector
    import wake_pkg::*;
#(
    parameter int NUM_TPL = 4,
    parameter int WINDOW  = 64,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eof,
    input  logic              link_up,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic              wake_n
);
    localparam int NSRC       = SRC_TPL0 + NUM_TPL;
    localparam int CNT_W      = $clog2(WINDOW) + 1;
    localparam int MASK_WORDS = WINDOW / 16;

    typedef struct packed {
        logic                             out_en;
        logic [NSRC-1:0]                  en;
        logic [NSRC-1:0]                  flag;
        logic [CNT_W-1:0]                 cnt;
        logic [NUM_TPL-1:0][WINDOW-1:0]   mask;
        logic [NUM_TPL-1:0][31:0]         exp;
    } state_t;

    state_t           s_d, s_q;
    logic [CNT_W-1:0] byte_idx;
    logic [NUM_TPL-1:0] tpl_hit;
    logic             link_rise, link_fall;
    logic [NSRC-1:0]  live, set;

    wake_link_edge u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .went_up   (link_rise),
        .went_down (link_fall)
    );

    assign byte_idx = rx_sof ? '0 : s_q.cnt;

    for (genvar t = 0; t < NUM_TPL; t++) begin : g_lane
        wake_crc_lane #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .rx_sof   (rx_sof),
            .rx_valid (rx_valid),
            .rx_eof   (rx_eof),
            .rx_data  (rx_data),
            .byte_idx (byte_idx),
            .mask     (s_q.mask[t]),
            .exp_crc  (s_q.exp[t]),
            .hit      (tpl_hit[t])
        );
    end

    always_comb begin
        s_d = s_q;

        if (rx_valid && byte_idx < CNT_W'(WINDOW)) s_d.cnt = byte_idx + 1'b1;
        else if (rx_valid)                         s_d.cnt = byte_idx;

        if (cfg_we) begin
            if (cfg_addr == ADDR_W'(CTRL_ADDR)) begin
                s_d.out_en = cfg_wdata[OE_BIT];
                s_d.en     = cfg_wdata[NSRC-1:0];
            end
            for (int t = 0; t < NUM_TPL; t++) begin
                for (int w = 0; w < MASK_WORDS; w++) begin
                    if (cfg_addr == ADDR_W'(TPL_BASE + t*TPL_STRIDE + w))
                        s_d.mask[t][w*16 +: 16] = cfg_wdata;
                end
                if (cfg_addr == ADDR_W'(TPL_BASE + t*TPL_STRIDE + OFF_CRC_LO))
                    s_d.exp[t][15:0] = cfg_wdata;
                if (cfg_addr == ADDR_W'(TPL_BASE + t*TPL_STRIDE + OFF_CRC_HI))
                    s_d.exp[t][31:16] = cfg_wdata;
            end
        end

        live = s_q.flag & s_q.en;
        set  = {tpl_hit, link_fall, link_rise};
        s_d.flag = (live | (set & s_q.en)) & s_d.en;
        wake_n   = !(s_q.out_en && (|live));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wake_crc_checker.sv
module wake_crc_checker #(
    parameter int NSRC   = 6,
    parameter int CNT_W  = 7,
    parameter int ADDR_W = 6,
    parameter int WINDOW = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_eof,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [15:0]       cfg_wdata,
    input logic              wake_n,
    input logic [CNT_W-1:0]  cnt,
    input logic              link_evt
);
    logic ctrl_wr;
    assign ctrl_wr = cfg_we && (cfg_addr == '0);

    // R9: request holds through any cycle with no control write
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_n && !ctrl_wr) |=> !wake_n);

    // R9: clearing every enable releases the request next cycle
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cfg_wdata[NSRC-1:0] == '0) |=> wake_n);

    // R5/R8/R10: every assertion follows a frame end, link change or control write
    assert_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_n) |-> ($past(rx_valid && rx_eof) || $past(link_evt) || $past(ctrl_wr)));

    // R4: byte position never runs past the window
    assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WINDOW));
endmodule

bind wake_crc_detector wake_crc_checker #(
    .NSRC(NSRC), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .WINDOW(WINDOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_eof    (rx_eof),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .wake_n    (wake_n),
    .cnt       (s_q.cnt),
    .link_evt  (link_rise || link_fall)
);

// File: tb/wake_crc_detector_bench.sv
`timescale 1ns/1ps
module wake_crc_detector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        link_up = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        wake_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] fr [0:127];

    always #2 clk = ~clk;

    wake_crc_detector u_wake_crc_detector (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eof(rx_eof), .link_up(link_up),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .wake_n(wake_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s wake_n actual %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [63:0] m, input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len && i < 64; i++) begin
            if (m[i]) begin
                for (int k = 0; k < 8; k++) begin
                    logic fb;
                    fb = c[0] ^ fr[i][k];
                    c  = {1'b0, c[31:1]};
                    if (fb) c = c ^ 32'hEDB8_8320;
                end
            end
        end
        return ~c;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 128; i++) fr[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2));
    endtask

    task automatic wr(input int addr, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_tpl(input int t, input logic [63:0] m, input logic [31:0] c);
        for (int w = 0; w < 4; w++) wr(8 + 8*t + w, m[w*16 +: 16]);
        wr(8 + 8*t + 4, c[15:0]);
        wr(8 + 8*t + 5, c[31:16]);
    endtask

    task automatic send(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fr[i];
            rx_sof = (i == 0); rx_eof = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset", wake_n, 1'b1);
        fill(1);
        set_tpl(0, 64'h3F, ref_crc(64'h3F, 20));
        send(20);
        chk("R1 enables cleared", wake_n, 1'b1);
    endtask

    task automatic t_basic;
        fill(1);
        set_tpl(0, 64'h3F, ref_crc(64'h3F, 20));
        wr(0, 16'h8004);
        chk("R5 idle before frame", wake_n, 1'b1);
        send(20);
        chk("R3 R5 template 0 match", wake_n, 1'b0);
        wr(0, 16'h8000);
        chk("R9 release on clear", wake_n, 1'b1);
        fr[10] = fr[10] ^ 8'hA5;
        wr(0, 16'h8004);
        send(20);
        chk("R3 unmasked byte ignored", wake_n, 1'b0);
        wr(0, 16'h8000);
    endtask

    task automatic t_mismatch;
        fill(1);
        set_tpl(0, 64'h3F, ref_crc(64'h3F, 20) ^ 32'h1);
        wr(0, 16'h8004);
        send(20);
        chk("R6 crc mismatch", wake_n, 1'b1);
        set_tpl(0, 64'h3F, ref_crc(64'h3F, 20));
        wr(0, 16'h8000);
        send(20);
        chk("R6 disabled template", wake_n, 1'b1);
    endtask

    task automatic t_window;
        logic [63:0] all = '1;
        logic [31:0] c;
        fill(2);
        c = ref_crc(all, 100);
        set_tpl(1, all, c);
        wr(0, 16'h8008);
        send(100);
        chk("R4 long frame uses first 64", wake_n, 1'b0);
        wr(0, 16'h8000);
        fr[80] = fr[80] ^ 8'hFF;
        fr[64] = fr[64] ^ 8'h3C;
        wr(0, 16'h8008);
        send(100);
        chk("R4 bytes past 64 ignored", wake_n, 1'b0);
        wr(0, 16'h8000);
    endtask

    task automatic t_short;
        logic [63:0] all = '1;
        fill(3);
        set_tpl(2, all, ref_crc(all, 10));
        wr(0, 16'h8010);
        send(10);
        chk("R7 short frame", wake_n, 1'b0);
        wr(0, 16'h8000);
    endtask

    task automatic t_scatter;
        logic [63:0] m = 64'h8000_0001_0100_0010;
        fill(4);
        set_tpl(3, m, ref_crc(m, 64));
        wr(0, 16'h8020);
        send(64);
        chk("R2 mask word positions", wake_n, 1'b0);
        wr(0, 16'h8021);
        chk("R9 keep-bit write holds", wake_n, 1'b0);
        wr(0, 16'h8000);
        chk("R9 clear releases", wake_n, 1'b1);
    endtask

    task automatic t_link;
        wr(0, 16'h8001);
        @(negedge clk); link_up = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 link-up", wake_n, 1'b0);
        wr(0, 16'h8000);
        wr(0, 16'h8001);
        @(negedge clk); link_up = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 wrong polarity ignored", wake_n, 1'b1);
        wr(0, 16'h8002);
        @(negedge clk); link_up = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 rise ignored by link-down", wake_n, 1'b1);
        @(negedge clk); link_up = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 link-down", wake_n, 1'b0);
        wr(0, 16'h8000);
        chk("R9 link clear", wake_n, 1'b1);
    endtask

    task automatic t_oe;
        fill(1);
        set_tpl(0, 64'h3F, ref_crc(64'h3F, 20));
        wr(0, 16'h0004);
        send(20);
        chk("R10 output gated", wake_n, 1'b1);
        wr(0, 16'h8004);
        chk("R10 flag kept", wake_n, 1'b0);
        wr(0, 16'h8000);
    endtask

    task automatic t_multi;
        logic [63:0] all = '1;
        fill(5);
        set_tpl(0, 64'h3F, ref_crc(64'h3F, 20));
        set_tpl(2, all, ref_crc(all, 20));
        wr(0, 16'h8014);
        send(20);
        chk("R11 two templates", wake_n, 1'b0);
        wr(0, 16'h8010);
        chk("R11 other template holds", wake_n, 1'b0);
        wr(0, 16'h8000);
        chk("R11 both cleared", wake_n, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mismatch();
        t_window();
        t_short();
        t_scatter();
        t_link();
        t_oe();
        t_multi();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule